// File: doc/BRIEF.md
# Adaptive Shunt Route Computation Unit

This unit decides where a packet leaving one node of a 4x4 mesh should go. It is given the source and destination node addresses and a congestion reading for each output port. From these it picks one of four outcomes. A packet for the node itself goes to the local port. A packet for a neighbour stays on the electrical mesh, either on its normal direction port or on an edge diversion port that would otherwise sit idle. A packet for any other node goes to the optical layer. When every allowed port is blocked, the unit reports a stall.

The choice between the normal port and the diversion port depends on two things. The first is the parity of the combined count of 1 bits in the two addresses. The second is a comparison of the two ports' congestion. A port whose occupancy reaches 80 percent of full scale is never chosen. The unit computes its answer from the request and registers it. The answer appears one cycle after a request, as a one-hot port vector with a valid strobe.

Top module: `shunt_route_unit`

## Requirements
- R1: A node address is X in bits [3:2] and Y in bits [1:0]. When the source equals the destination, the result is the local port (route_sel bit 0) and never a stall.
- R2: Two nodes are neighbours when one coordinate is equal and the other differs by exactly 1. The normal port for a neighbour is selected as follows:
  - south (bit 3) when destination X = source X + 1;
  - north (bit 1) when destination X = source X - 1;
  - east (bit 2) when destination Y = source Y + 1;
  - west (bit 4) when destination Y = source Y - 1.
- R3: A destination that is neither the node itself nor a neighbour goes to the optical port (bit 6), or stalls if that port is blocked.
- R4: For a neighbour, the unit adds the count of 1 bits in the source address to the count in the destination address.
  - An even sum allows only the normal port; the diversion port (bit 5) is never chosen.
  - An odd sum makes both the normal port and the diversion port candidates.
- R5: For an odd sum with both candidates unblocked, the diversion port is chosen when the normal port's occupancy is strictly greater than the diversion port's. Otherwise, including a tie, the normal port is chosen. Occupancy lane k of occ_vec (bits k*8 +: 8) belongs to port bit k+1.
- R6: A port is blocked when occupancy*5 >= 255*4, that is, occupancy 204 or more. Occupancy 203 is not blocked.
- R7: A blocked port is never selected. For an odd sum, if exactly one candidate is blocked, the other candidate is chosen.
- R8: If no allowed port is free, route_stall is 1 and route_sel is all zero. Otherwise route_sel is one-hot and route_stall is 0.
- R9: A request accepted at a clock edge produces route_valid, route_sel and route_stall right after the next edge. Requests may arrive back to back. In a cycle after no request, all three outputs are 0, whatever the other inputs carry.
- R10: While rst_n is low, route_valid, route_sel and route_stall are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A route request is present this cycle |
| src_addr | input | 4 | Address of the node issuing the packet |
| dst_addr | input | 4 | Address of the packet's destination |
| occ_vec | input | 48 | Six 8-bit occupancy lanes: north, east, south, west, diversion, optical |
| route_valid | output | 1 | Result strobe, one cycle after req_valid |
| route_sel | output | 7 | One-hot chosen port: local, north, east, south, west, diversion, optical |
| route_stall | output | 1 | No permitted port is free |

## Verification
The bench uses the default parameters: 2-bit coordinates, 8-bit occupancy and a full scale of 255. The mesh is small enough that every one of the 256 source and destination pairs can be swept. Each pair is run against seven occupancy patterns. These patterns include ties, a split between 203 and 204 on either side of the threshold, single and double blocking, and all ports saturated. Together they reach every branch of the parity, compare and fallback logic, and every direction from every node, including the mesh edges.

// File: rtl/shunt_route_pkg.sv
`timescale 1ns/1ps
package shunt_route_pkg;

  localparam int NPORT = 7;

  typedef enum logic [2:0] {
    P_LOCAL  = 3'd0,
    P_NORTH  = 3'd1,
    P_EAST   = 3'd2,
    P_SOUTH  = 3'd3,
    P_WEST   = 3'd4,
    P_DIVERT = 3'd5,
    P_OPTIC  = 3'd6
  } port_e;

  // number of set bits in a zero-extended address
  function automatic logic [4:0] bit_count(input logic [15:0] v);
    logic [4:0] n;
    n = '0;
    for (int i = 0; i < 16; i++) n = n + 5'(v[i]);
    return n;
  endfunction

  // a lane is blocked once occupancy reaches 4/5 of full scale
  function automatic logic over_thresh(input logic [15:0] occ, input logic [15:0] full);
    logic [31:0] lhs;
    logic [31:0] rhs;
    lhs = {16'b0, occ} * 32'd5;
    rhs = {16'b0, full} * 32'd4;
    return lhs >= rhs;
  endfunction

endpackage

// File: rtl/shunt_addr_classify.sv
`timescale 1ns/1ps
module shunt_addr_classify
  import shunt_route_pkg::*;
#(
  parameter int COORD_W = 2,
  localparam int ADDR_W = 2 * COORD_W
) (
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic              same_node,
  output logic              adjacent,
  output logic              odd_parity,
  output port_e             normal_port
);

  logic [COORD_W:0] sx, sy, dx, dy;
  logic x_eq, y_eq, x_inc, x_dec, y_inc, y_dec;
  logic [4:0] ones_sum;

  assign sx = {1'b0, src[ADDR_W-1:COORD_W]};
  assign sy = {1'b0, src[COORD_W-1:0]};
  assign dx = {1'b0, dst[ADDR_W-1:COORD_W]};
  assign dy = {1'b0, dst[COORD_W-1:0]};

  assign x_eq  = (sx == dx);
  assign y_eq  = (sy == dy);
  assign x_inc = (dx == sx + 1'b1);
  assign x_dec = (sx == dx + 1'b1);
  assign y_inc = (dy == sy + 1'b1);
  assign y_dec = (sy == dy + 1'b1);

  assign same_node = x_eq && y_eq;
  assign adjacent  = (x_eq && (y_inc || y_dec)) || (y_eq && (x_inc || x_dec));

  assign ones_sum   = bit_count(16'(src)) + bit_count(16'(dst));
  assign odd_parity = ones_sum[0];

  always_comb begin
    normal_port = P_LOCAL;
    if (y_eq && x_inc)      normal_port = P_SOUTH;
    else if (y_eq && x_dec) normal_port = P_NORTH;
    else if (x_eq && y_inc) normal_port = P_EAST;
    else if (x_eq && y_dec) normal_port = P_WEST;
  end

endmodule

// File: rtl/shunt_block_detect.sv
`timescale 1ns/1ps
module shunt_block_detect
  import shunt_route_pkg::*;
#(
  parameter int OCC_W   = 8,
  parameter int OCC_MAX = 255,
  localparam int NLANE  = NPORT - 1
) (
  input  logic [NLANE*OCC_W-1:0] occ_vec,
  output logic [NPORT-1:0]       blocked
);

  assign blocked[0] = 1'b0;  // local port has no congestion lane

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign blocked[k+1] = over_thresh(16'(occ_vec[k*OCC_W +: OCC_W]), 16'(OCC_MAX));
  end

endmodule

// File: rtl/shunt_port_select.sv
`timescale 1ns/1ps
module shunt_port_select
  import shunt_route_pkg::*;
#(
  parameter int OCC_W  = 8,
  localparam int NLANE = NPORT - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   same_node,
  input  logic                   adjacent,
  input  logic                   odd_parity,
  input  port_e                  normal_port,
  input  logic [NLANE*OCC_W-1:0] occ_vec,
  input  logic [NPORT-1:0]       blocked,
  output logic [NPORT-1:0]       pick,
  output logic                   stall
);

  logic [2:0]       n_lane;
  logic [OCC_W-1:0] occ_norm, occ_div;
  logic             norm_free, div_free, divert_wins;

  assign n_lane    = (normal_port == P_LOCAL) ? 3'd0 : 3'(normal_port) - 3'd1;
  assign occ_norm  = occ_vec[int'(n_lane)*OCC_W +: OCC_W];
  assign occ_div   = occ_vec[(int'(P_DIVERT)-1)*OCC_W +: OCC_W];
  assign norm_free = !blocked[normal_port];
  assign div_free  = !blocked[P_DIVERT];
  assign divert_wins = occ_norm > occ_div;

  always_comb begin
    pick  = '0;
    stall = 1'b0;
    if (same_node) begin
      pick[P_LOCAL] = 1'b1;
    end else if (!adjacent) begin
      if (!blocked[P_OPTIC]) pick[P_OPTIC] = 1'b1;
      else                   stall = 1'b1;
    end else if (odd_parity) begin
      if (norm_free && div_free) begin
        if (divert_wins) pick[P_DIVERT] = 1'b1;
        else             pick[normal_port] = 1'b1;
      end else if (norm_free) begin
        pick[normal_port] = 1'b1;
      end else if (div_free) begin
        pick[P_DIVERT] = 1'b1;
      end else begin
        stall = 1'b1;
      end
    end else begin
      if (norm_free) pick[normal_port] = 1'b1;
      else           stall = 1'b1;
    end
  end

  AST_NO_BLOCKED_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((pick & blocked) == '0)); // R7

  AST_FAR_GOES_OPTIC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !same_node && !adjacent) |-> ((pick == 7'b1000000) || stall)); // R3

  AST_DIVERT_NEEDS_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pick[P_DIVERT]) |-> (adjacent && odd_parity)); // R4

  AST_DIVERT_LESS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pick[P_DIVERT] && !blocked[normal_port]) |-> (occ_norm > occ_div)); // R5

endmodule

// File: rtl/shunt_route_unit.sv
`timescale 1ns/1ps
module shunt_route_unit
  import shunt_route_pkg::*;
#(
  parameter int COORD_W = 2,
  parameter int OCC_W   = 8,
  parameter int OCC_MAX = 255,
  localparam int ADDR_W = 2 * COORD_W,
  localparam int NLANE  = NPORT - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      src_addr,
  input  logic [ADDR_W-1:0]      dst_addr,
  input  logic [NLANE*OCC_W-1:0] occ_vec,
  output logic                   route_valid,
  output logic [NPORT-1:0]       route_sel,
  output logic                   route_stall
);

  logic       same_node, adjacent, odd_parity;
  port_e      normal_port;
  logic [NPORT-1:0] blocked, pick;
  logic       stall;

  shunt_addr_classify #(.COORD_W(COORD_W)) u_classify (
    .src(src_addr), .dst(dst_addr),
    .same_node(same_node), .adjacent(adjacent),
    .odd_parity(odd_parity), .normal_port(normal_port)
  );

  shunt_block_detect #(.OCC_W(OCC_W), .OCC_MAX(OCC_MAX)) u_block (
    .occ_vec(occ_vec), .blocked(blocked)
  );

  shunt_port_select #(.OCC_W(OCC_W)) u_select (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .same_node(same_node), .adjacent(adjacent), .odd_parity(odd_parity),
    .normal_port(normal_port), .occ_vec(occ_vec), .blocked(blocked),
    .pick(pick), .stall(stall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_valid <= 1'b0;
      route_sel   <= '0;
      route_stall <= 1'b0;
    end else if (req_valid) begin
      route_valid <= 1'b1;
      route_sel   <= pick;
      route_stall <= stall;
    end else begin
      route_valid <= 1'b0;
      route_sel   <= '0;
      route_stall <= 1'b0;
    end
  end

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> route_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!route_valid && (route_sel == '0) && !route_stall)); // R9

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> ($onehot0(route_sel) && ((route_sel == '0) == route_stall))); // R8

  AST_SAME_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (src_addr == dst_addr)) |=> (route_sel == 7'b0000001)); // R1

endmodule

// File: tb/tb_shunt_route_unit.sv
`timescale 1ns/1ps
module tb_shunt_route_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  src_addr = '0;
  logic [3:0]  dst_addr = '0;
  logic [47:0] occ_vec = '0;
  logic        route_valid;
  logic [6:0]  route_sel;
  logic        route_stall;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shunt_route_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .src_addr(src_addr), .dst_addr(dst_addr), .occ_vec(occ_vec),
    .route_valid(route_valid), .route_sel(route_sel), .route_stall(route_stall)
  );

  // lanes: north, east, south, west, diversion, optical
  int pat [7][6] = '{
    '{  0,   0,   0,   0,   0,   0},
    '{ 10,  50,  90, 130,  70,   0},
    '{210,  30, 205,   0,  40, 210},
    '{203, 203, 203, 203, 204, 203},
    '{255, 255, 255, 255, 255, 255},
    '{ 60,  60,  60,  60,  60, 100},
    '{200, 200, 200, 200,   5, 204}
  };

  function automatic bit is_blk(input int v);
    return (v * 5) >= (255 * 4);
  endfunction

  function automatic int ones4(input int v);
    int c = 0;
    for (int i = 0; i < 4; i++) c += (v >> i) & 1;
    return c;
  endfunction

  // expected port number, or -1 for stall; tag names the governing requirement
  task automatic model(input int s, input int d, input int p, output int port, output string tag);
    int sx, sy, dx, dy, nrm;
    bit adj;
    sx = s >> 2; sy = s & 3; dx = d >> 2; dy = d & 3;
    adj = ((sx == dx) && ((dy - sy == 1) || (sy - dy == 1))) ||
          ((sy == dy) && ((dx - sx == 1) || (sx - dx == 1)));
    if (s == d) begin
      port = 0; tag = "R1";
    end else if (!adj) begin
      port = is_blk(pat[p][5]) ? -1 : 6;
      tag = (port < 0) ? "R3/R8" : "R3";
    end else begin
      if (dx == sx + 1)      nrm = 3;
      else if (dx == sx - 1) nrm = 1;
      else if (dy == sy + 1) nrm = 2;
      else                   nrm = 4;
      if (((ones4(s) + ones4(d)) % 2) == 0) begin
        port = is_blk(pat[p][nrm-1]) ? -1 : nrm;
        tag = (port < 0) ? "R4/R8" : "R2/R4";
      end else begin
        bit nf, df;
        nf = !is_blk(pat[p][nrm-1]);
        df = !is_blk(pat[p][4]);
        if (nf && df) begin
          port = (pat[p][nrm-1] > pat[p][4]) ? 5 : nrm; tag = "R5";
        end else if (nf) begin
          port = nrm; tag = "R6/R7";
        end else if (df) begin
          port = 5; tag = "R6/R7";
        end else begin
          port = -1; tag = "R7/R8";
        end
      end
    end
  endtask

  task automatic check(input string tag, input bit v, input logic [6:0] sel, input bit st);
    n_checks++;
    if (route_valid !== v || route_sel !== sel || route_stall !== st) begin
      n_fails++;
      $display("FAIL %s: got valid=%0b sel=%b stall=%0b, expected valid=%0b sel=%b stall=%0b",
               tag, route_valid, route_sel, route_stall, v, sel, st);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got running, expected done");
    finish_run();
  end

  initial begin
    int port;
    string tag;
    logic [6:0] esel;
    // reset with a request pending: outputs must stay zero (R10)
    req_valid = 1'b1; src_addr = 4'd0; dst_addr = 4'd5;
    repeat (3) @(posedge clk);
    #1 check("R10", 1'b0, 7'd0, 1'b0);
    @(negedge clk); rst_n = 1'b1; req_valid = 1'b0;
    @(posedge clk); #1 check("R9", 1'b0, 7'd0, 1'b0);

    for (int p = 0; p < 7; p++) begin
      for (int s = 0; s < 16; s++) begin
        for (int d = 0; d < 16; d++) begin
          @(negedge clk);
          req_valid = 1'b1;
          src_addr  = 4'(s);
          dst_addr  = 4'(d);
          for (int k = 0; k < 6; k++) occ_vec[k*8 +: 8] = 8'(pat[p][k]);
          model(s, d, p, port, tag);
          esel = (port < 0) ? 7'd0 : 7'(1 << port);
          @(posedge clk); #1;
          check(tag, 1'b1, esel, port < 0);
        end
      end
      // idle cycle with changing inputs must produce nothing (R9)
      @(negedge clk);
      req_valid = 1'b0; src_addr = 4'd3; dst_addr = 4'd12; occ_vec = '1;
      @(posedge clk); #1 check("R9", 1'b0, 7'd0, 1'b0);
    end
    finish_run();
  end

endmodule